// File: doc/BRIEF.md
# MDIO Clause 45 Managed Device Responder

This block is the device side of a two-wire management link. It watches the shared bidirectional data line and samples it on each rising edge of the management clock. It waits for a long run of ones followed by a two-bit start marker. It then decodes an opcode, a 5-bit port field and a 5-bit device field, and compares both fields with the values on its configuration inputs. The management clock is oversampled by the block's own system clock, so all logic stays in a single clock domain.

An internal 16-bit pointer holds its value from one frame to the next. An address frame loads the pointer. A write frame stores its payload, through a simple local register-file port, at the location the pointer names. A read frame fetches that location in the same system cycle, releases the line for the first turnaround bit, drives a 0 in the second, and then shifts the 16-bit word out. The block never drives the line for any other kind of frame or for a frame addressed elsewhere.

Top module: `mdio_c45_responder`

## Requirements
- R1: A frame is accepted only after at least 32 consecutive 1 bits followed by two 0 bits. After the start bits the fields arrive in this order: a 2-bit opcode, a 5-bit port field, a 5-bit device field, two turnaround bits and a 16-bit payload. With 31 ones the frame is ignored.
- R2: Opcode 00 loads the payload into the pointer. `rf_addr` shows the pointer, and the value persists across later frames.
- R3: Opcode 01 produces exactly one system-cycle pulse on `rf_we`, with `rf_addr` equal to the stored pointer and `rf_wdata` equal to the payload.
- R4: Opcode 11 returns the register-file word at the stored pointer on the line, bit 15 first.
- R5: During a read, the line is released in the first turnaround bit and driven to 0 in the second.
- R6: The port and device fields are received MSB first and must both equal `cfg_port` and `cfg_dev`.
- R7: A frame whose port or device field does not match causes no write, leaves the pointer unchanged and never drives the line.
- R8: Opcode 10 is unsupported. It causes no write, no pointer change and no drive.
- R9: A 0 bit seen before 32 ones have been counted restarts the preamble count from zero.
- R10: After the last data bit of a read, the line is released before the next rising edge, and a new frame can follow at once.
- R11: Under reset, `mdio_oe` and `rf_we` are 0 and the pointer is 0.
- R12: The line is sampled at rising management-clock edges. `mdio_o` and `mdio_oe` change only in the system cycle after a falling edge is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the management clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_port | input | 5 | Port address this device answers to |
| cfg_dev | input | 5 | Device address this device answers to |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | Resolved level of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line driver |
| rf_we | output | 1 | Register-file write strobe, one cycle |
| rf_addr | output | 16 | Stored register pointer |
| rf_wdata | output | 16 | Register-file write data |
| rf_rdata | input | 16 | Register-file read data, valid in the same cycle as rf_addr |

## Verification
The bench builds the block with its defaults: 16-bit payload, 5-bit address fields, a 32-one preamble threshold and a two-stage synchronizer, with a management clock of 16 system cycles. These values put the exact preamble boundary (31 against 32 ones) within reach. They also allow a 0 placed after 20 ones, which tells a restarted count apart from an accumulating one. The configured port 00101 and device 00011 read differently when reversed, so a bit-order error in either field turns into a mismatch the bench can see. The half-period of eight system cycles leaves room for the synchronizer and output register, so every driven bit can be sampled just before the rising edge that the station would use.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

  typedef enum logic [2:0] {
    S_PRE,
    S_SOF,
    S_OP,
    S_PRT,
    S_DEV,
    S_TA,
    S_DAT
  } rx_state_e;

  localparam logic [1:0] OPC_ADDR  = 2'b00;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_RSVD  = 2'b10;
  localparam logic [1:0] OPC_READ  = 2'b11;

endpackage

// File: rtl/mdio_c45_sync.sv
module mdio_c45_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic mdc_i,
  input  logic dat_i,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] mdc_s;
  logic [STAGES-1:0] dat_s;
  logic              mdc_d;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) begin
          mdc_s[0] <= 1'b0;
          dat_s[0] <= 1'b1;
        end else begin
          mdc_s[0] <= mdc_i;
          dat_s[0] <= dat_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) begin
          mdc_s[g] <= 1'b0;
          dat_s[g] <= 1'b1;
        end else begin
          mdc_s[g] <= mdc_s[g-1];
          dat_s[g] <= dat_s[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_d  <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
      bit_o  <= 1'b1;
    end else begin
      mdc_d  <= mdc_s[LAST];
      rise_o <= mdc_s[LAST] & ~mdc_d;
      fall_o <= ~mdc_s[LAST] & mdc_d;
      bit_o  <= dat_s[LAST];
    end
  end

  // R12: a single detected event per edge, never both at once
  p_edge_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o));

endmodule

// File: rtl/mdio_c45_rx.sv
module mdio_c45_rx
  import mdio_c45_pkg::*;
#(
  parameter int DW      = 16,
  parameter int FW      = 5,
  parameter int PRE_LEN = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise_i,
  input  logic          bit_i,
  input  logic [FW-1:0] cfg_port_i,
  input  logic [FW-1:0] cfg_dev_i,
  output logic [DW-1:0] addr_o,
  output logic          we_o,
  output logic [DW-1:0] wdata_o,
  output logic          rd_go_o,
  output logic          frame_rd_o
);

  localparam int PC_W = $clog2(PRE_LEN + 1);
  localparam int BC_W = $clog2(DW);
  localparam logic [PC_W-1:0] PRE_MAX = PC_W'(PRE_LEN);

  rx_state_e       state;
  logic [PC_W-1:0] pre_cnt;
  logic [BC_W-1:0] bit_cnt;
  logic [DW-2:0]   sh;
  logic [1:0]      op_q;
  logic            hit;
  logic            last;
  logic [DW-1:0]   payload;
  logic [FW-1:0]   fld;

  assign payload = {sh, bit_i};
  assign fld     = payload[FW-1:0];

  always_comb begin
    unique case (state)
      S_OP, S_TA:   last = (bit_cnt == BC_W'(1));
      S_PRT, S_DEV: last = (bit_cnt == BC_W'(FW - 1));
      S_DAT:        last = (bit_cnt == BC_W'(DW - 1));
      default:      last = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_PRE;
      pre_cnt    <= '0;
      bit_cnt    <= '0;
      sh         <= '0;
      op_q       <= '0;
      hit        <= 1'b0;
      addr_o     <= '0;
      we_o       <= 1'b0;
      wdata_o    <= '0;
      rd_go_o    <= 1'b0;
      frame_rd_o <= 1'b0;
    end else begin
      we_o    <= 1'b0;
      rd_go_o <= 1'b0;
      if (rise_i) begin
        sh <= payload[DW-2:0];
        if (state inside {S_OP, S_PRT, S_DEV, S_TA, S_DAT})
          bit_cnt <= last ? '0 : bit_cnt + 1'b1;
        unique case (state)
          S_PRE: begin
            if (bit_i) begin
              if (pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
            end else begin
              if (pre_cnt == PRE_MAX) state <= S_SOF;
              pre_cnt <= '0;
            end
          end
          S_SOF: begin
            if (!bit_i) begin
              state      <= S_OP;
              bit_cnt    <= '0;
              frame_rd_o <= 1'b0;
            end else begin
              state   <= S_PRE;
              pre_cnt <= PC_W'(1);
            end
          end
          S_OP: begin
            op_q <= {op_q[0], bit_i};
            if (last) state <= S_PRT;
          end
          S_PRT: begin
            if (last) begin
              hit   <= (fld == cfg_port_i);
              state <= S_DEV;
            end
          end
          S_DEV: begin
            if (last) begin
              hit   <= hit && (fld == cfg_dev_i);
              state <= S_TA;
              if (hit && (fld == cfg_dev_i) && (op_q == OPC_READ)) begin
                rd_go_o    <= 1'b1;
                frame_rd_o <= 1'b1;
              end
            end
          end
          S_TA: begin
            if (last) state <= S_DAT;
          end
          S_DAT: begin
            if (last) begin
              state   <= S_PRE;
              pre_cnt <= '0;
              if (hit) begin
                unique case (op_q)
                  OPC_ADDR:  addr_o <= payload;
                  OPC_WRITE: begin
                    we_o    <= 1'b1;
                    wdata_o <= payload;
                  end
                  default: ;
                endcase
              end
            end
          end
          default: state <= S_PRE;
        endcase
      end
    end
  end

  // R3: the write strobe lasts one cycle
  p_we_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    we_o |=> !we_o);

  // R3: a write never disturbs the stored pointer
  p_we_addr_hold_r3: assert property (@(posedge clk) disable iff (rst)
    we_o |-> $stable(addr_o));

  // R1: preamble counter stays within its threshold
  p_pre_bound_r1: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= PRE_MAX);

  // R1: start detection only follows a full preamble
  p_sof_after_pre_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(state == S_SOF) |-> ($past(pre_cnt) == PRE_MAX));

  // R8: a read is launched only for opcode 11
  p_rd_only_op11_r8: assert property (@(posedge clk) disable iff (rst)
    rd_go_o |-> (op_q == OPC_READ));

endmodule

// File: rtl/mdio_c45_tx.sv
module mdio_c45_tx #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_i,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic          oe_o,
  output logic          out_o
);

  localparam int CW = $clog2(DW + 3);

  logic [CW-1:0] cnt;
  logic          busy;
  logic [DW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      busy  <= 1'b0;
      sh    <= '0;
      oe_o  <= 1'b0;
      out_o <= 1'b0;
    end else if (load_i) begin
      busy <= 1'b1;
      cnt  <= '0;
      sh   <= data_i;
    end else if (fall_i && busy) begin
      cnt <= cnt + 1'b1;
      if (cnt == CW'(1)) begin
        oe_o  <= 1'b1;
        out_o <= 1'b0;
      end else if (cnt == CW'(DW + 2)) begin
        oe_o  <= 1'b0;
        out_o <= 1'b0;
        busy  <= 1'b0;
      end else if (cnt >= CW'(2)) begin
        out_o <= sh[DW-1];
        sh    <= {sh[DW-2:0], 1'b0};
      end
    end
  end

  // R5: the first driven bit is the 0 of the second turnaround bit
  p_ta_zero_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_o) |-> !out_o);

  // R12: line outputs move only right after a falling edge
  p_tx_edge_only_r12: assert property (@(posedge clk) disable iff (rst)
    !$past(fall_i) |-> ($stable(oe_o) && $stable(out_o)));

endmodule

// File: rtl/mdio_c45_responder.sv
module mdio_c45_responder #(
  parameter int DATA_W      = 16,
  parameter int FIELD_W     = 5,
  parameter int PRE_LEN     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] cfg_port,
  input  logic [FIELD_W-1:0] cfg_dev,
  input  logic               mdc,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               rf_we,
  output logic [DATA_W-1:0]  rf_addr,
  output logic [DATA_W-1:0]  rf_wdata,
  input  logic [DATA_W-1:0]  rf_rdata
);

  logic rise, fall, sbit;
  logic rd_go, frame_rd;

  mdio_c45_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .mdc_i  (mdc),
    .dat_i  (mdio_i),
    .rise_o (rise),
    .fall_o (fall),
    .bit_o  (sbit)
  );

  mdio_c45_rx #(.DW(DATA_W), .FW(FIELD_W), .PRE_LEN(PRE_LEN)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (rise),
    .bit_i      (sbit),
    .cfg_port_i (cfg_port),
    .cfg_dev_i  (cfg_dev),
    .addr_o     (rf_addr),
    .we_o       (rf_we),
    .wdata_o    (rf_wdata),
    .rd_go_o    (rd_go),
    .frame_rd_o (frame_rd)
  );

  mdio_c45_tx #(.DW(DATA_W)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .fall_i (fall),
    .load_i (rd_go),
    .data_i (rf_rdata),
    .oe_o   (mdio_oe),
    .out_o  (mdio_o)
  );

  // R7: the line is driven only inside a matching read frame
  p_drive_gated_r7: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> frame_rd);

endmodule

// File: tb/sim_mdio_c45_responder.sv
module sim_mdio_c45_responder;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdc = 1'b0;
  logic        host_en = 1'b0;
  logic        host_val = 1'b1;
  logic [4:0]  cfg_port = 5'b00101;
  logic [4:0]  cfg_dev  = 5'b00011;
  logic        mdio_line, mdio_o, mdio_oe, rf_we;
  logic [15:0] rf_addr, rf_wdata, rf_rdata;
  logic [15:0] rf_mem [256];

  int vectors = 0;
  int miscompares = 0;
  int stray = 0;
  int cyc = 0;
  bit drive_ok = 1'b0;
  logic [31:0] exp_q [$];
  logic [15:0] model_addr = '0;
  logic [15:0] model_mem [256];

  always #2 clk = ~clk;

  assign mdio_line = host_en ? host_val : (mdio_oe ? mdio_o : 1'b1);
  assign rf_rdata  = rf_mem[rf_addr[7:0]];

  always @(posedge clk) if (rf_we) rf_mem[rf_addr[7:0]] <= rf_wdata;

  mdio_c45_responder u0 (
    .clk      (clk),
    .rst      (rst),
    .cfg_port (cfg_port),
    .cfg_dev  (cfg_dev),
    .mdc      (mdc),
    .mdio_i   (mdio_line),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rf_we    (rf_we),
    .rf_addr  (rf_addr),
    .rf_wdata (rf_wdata),
    .rf_rdata (rf_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clkwait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input bit drv, input bit val, output logic s_oe, output logic s_out);
    host_en  = drv;
    host_val = val;
    clkwait(HALF);
    s_oe  = mdio_oe;
    s_out = mdio_o;
    mdc = 1'b1;
    clkwait(HALF);
    mdc = 1'b0;
  endtask

  task automatic send(input bit b);
    logic a, c;
    bit_cycle(1'b1, b, a, c);
  endtask

  task automatic frame(input int brk, input int pre, input logic [1:0] op,
                       input logic [4:0] prt, input logic [4:0] dev,
                       input logic [15:0] pay, input bit rd, input bit exp_drive,
                       input logic [15:0] exp_word, input string tag);
    logic so, sd;
    logic [15:0] got;
    send(1'b0);
    if (brk > 0) begin
      repeat (brk) send(1'b1);
      send(1'b0);
    end
    repeat (pre) send(1'b1);
    send(1'b0);
    send(1'b0);
    for (int i = 1; i >= 0; i--) send(op[i]);
    for (int i = 4; i >= 0; i--) send(prt[i]);
    for (int i = 4; i >= 0; i--) send(dev[i]);
    if (!rd) begin
      send(1'b1);
      send(1'b0);
      for (int i = 15; i >= 0; i--) send(pay[i]);
    end else begin
      drive_ok = exp_drive;
      bit_cycle(1'b0, 1'b1, so, sd);
      check(so == 1'b0, "R5 first turnaround released", 32'(so), 32'd0);
      bit_cycle(1'b0, 1'b1, so, sd);
      if (exp_drive)
        check(so && !sd, "R5 second turnaround driven 0", {30'd0, so, sd}, 32'd2);
      for (int i = 15; i >= 0; i--) begin
        bit_cycle(1'b0, 1'b1, so, sd);
        got[i] = so ? sd : 1'b1;
      end
      check(got == exp_word, tag, 32'(got), 32'(exp_word));
      bit_cycle(1'b0, 1'b1, so, sd);
      check(so == 1'b0, "R10 line released after read", 32'(so), 32'd0);
      drive_ok = 1'b0;
    end
    host_en  = 1'b1;
    host_val = 1'b1;
  endtask

  function automatic bit hits(input logic [4:0] prt, input logic [4:0] dev);
    return (prt == cfg_port) && (dev == cfg_dev);
  endfunction

  task automatic do_addr(input int pre, input logic [4:0] prt, input logic [4:0] dev, input logic [15:0] a);
    if (hits(prt, dev)) model_addr = a;
    frame(0, pre, 2'b00, prt, dev, a, 1'b0, 1'b0, 16'h0, "R2");
  endtask

  task automatic do_write(input logic [4:0] prt, input logic [4:0] dev, input logic [15:0] d);
    if (hits(prt, dev)) begin
      exp_q.push_back({model_addr, d});
      model_mem[model_addr[7:0]] = d;
    end
    frame(0, 32, 2'b01, prt, dev, d, 1'b0, 1'b0, 16'h0, "R3");
  endtask

  task automatic do_read(input logic [4:0] prt, input logic [4:0] dev, input string tag);
    if (hits(prt, dev))
      frame(0, 32, 2'b11, prt, dev, 16'h0, 1'b1, 1'b1, model_mem[model_addr[7:0]], tag);
    else
      frame(0, 32, 2'b11, prt, dev, 16'h0, 1'b1, 1'b0, 16'hFFFF, tag);
  endtask

  // scoreboard monitor: every write strobe must match the next expected item
  always @(negedge clk) begin
    if (!rst && rf_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected write", {rf_addr, rf_wdata}, 32'h0);
      end else begin
        logic [31:0] item;
        item = exp_q.pop_front();
        check({rf_addr, rf_wdata} == item, "R3 write address/data", {rf_addr, rf_wdata}, item);
      end
    end
  end

  always @(negedge clk) if (!rst && mdio_oe && !drive_ok) stray++;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    host_en = 1'b1;
    clkwait(5);
    check(mdio_oe == 1'b0, "R11 oe in reset", 32'(mdio_oe), 32'd0);
    rst = 1'b0;
    clkwait(3);
    check(mdio_oe == 1'b0 && rf_we == 1'b0, "R11 outputs after reset", {mdio_oe, rf_we}, 32'd0);
    check(rf_addr == 16'h0, "R11 pointer after reset", 32'(rf_addr), 32'd0);

    // R2 address load, R3 write, R4 read back
    do_addr(32, cfg_port, cfg_dev, 16'h0012);
    check(rf_addr == 16'h0012, "R2 pointer loaded", 32'(rf_addr), 32'h12);
    do_write(cfg_port, cfg_dev, 16'hBEEF);
    do_read(cfg_port, cfg_dev, "R4 read 0012");

    // R1 longer preamble accepted
    do_addr(40, cfg_port, cfg_dev, 16'h0034);
    check(rf_addr == 16'h0034, "R1 long preamble accepted", 32'(rf_addr), 32'h34);
    do_write(cfg_port, cfg_dev, 16'h1234);
    do_read(cfg_port, cfg_dev, "R4 read 0034");

    // R2 pointer persists across frames
    do_addr(32, cfg_port, cfg_dev, 16'h0012);
    do_read(cfg_port, cfg_dev, "R2 persistence read");
    do_read(cfg_port, cfg_dev, "R10 back-to-back read");

    // R6/R7 mismatches (bit-reversed fields)
    do_read(5'b10100, cfg_dev, "R7 port mismatch read released");
    do_write(cfg_port, 5'b11000, 16'hDEAD);
    do_read(cfg_port, cfg_dev, "R6 device mismatch left memory");
    do_addr(32, 5'b00110, cfg_dev, 16'h0077);
    check(rf_addr == 16'h0012, "R7 mismatch kept pointer", 32'(rf_addr), 32'h12);

    // R8 opcode 10 ignored
    frame(0, 32, 2'b10, cfg_port, cfg_dev, 16'h0, 1'b1, 1'b0, 16'hFFFF, "R8 op10 no drive");
    check(rf_addr == 16'h0012, "R8 op10 kept pointer", 32'(rf_addr), 32'h12);

    // R1 preamble boundary: 31 ones ignored
    frame(0, 31, 2'b00, cfg_port, cfg_dev, 16'h0055, 1'b0, 1'b0, 16'h0, "R1");
    check(rf_addr == 16'h0012, "R1 31-one preamble ignored", 32'(rf_addr), 32'h12);

    // R9 restart on a mid-preamble 0
    frame(20, 31, 2'b00, cfg_port, cfg_dev, 16'h0066, 1'b0, 1'b0, 16'h0, "R9");
    check(rf_addr == 16'h0012, "R9 broken preamble ignored", 32'(rf_addr), 32'h12);
    frame(20, 32, 2'b00, cfg_port, cfg_dev, 16'h0066, 1'b0, 1'b0, 16'h0, "R9");
    model_addr = 16'h0066;
    check(rf_addr == 16'h0066, "R9 full run after break accepted", 32'(rf_addr), 32'h66);
    do_write(cfg_port, cfg_dev, 16'h5A5A);
    do_read(cfg_port, cfg_dev, "R4 read 0066");

    clkwait(50);
    check(exp_q.size() == 0, "R3 all expected writes seen", 32'(exp_q.size()), 32'd0);
    check(stray == 0, "R7 no drive outside matching reads", 32'(stray), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule